// File: doc/BRIEF.md
# Cascadable Reload Timer Group

This block holds three down-counting timers, eight bits wide by default. Each timer has its own reload latch. One shared control register sets how the group behaves. A single write port updates that control register or the value of any timer. A registered read port returns the control register or the live count of any timer. The timers do not count on every clock. Each one counts on a one-cycle enable chosen from prescaled tick inputs. The second and third timers can also count on the underflow of the first timer, which lets the timers be chained into longer periods.

Each timer raises its own one-cycle interrupt request when it underflows. A toggle output follows the second timer. It can be turned on or off, and its starting level can be chosen. The second timer has a deferred write mode: a write can go to the latch alone, and the counter picks up the new value at its next reload. Clock division, pin multiplexing and interrupt arbitration are not part of this block.

Top module: `rtim_group`

## Requirements
- R1: After a synchronous reset, every counter and latch holds all ones. The control register is 0, `irq` is 0, `tgl_out` is 1 and `rd_data` is 0.
- R2: A write with `wr_addr` 0 sets the control register. Addresses 1, 2 and 3 select the first, second and third timer. A read returns the addressed item one cycle after `rd_addr` is presented. Control bit 7 is not stored and always reads back as 0.
- R3: A timer whose count enable is high decrements by one. When it is enabled at a count of 0, it reloads from its latch. With no writes, the period is the latch value plus one enabled ticks. Without an enable, the count holds.
- R4: Control bits [5:4] pick the first timer's source. 00 is `tick_d16`, 01 is `tick_d2`, 10 is `tick_sub`, and with 11 the first timer never counts.
- R5: Control bit 3 sets the second timer's source and bit 6 sets the third timer's. A value of 0 counts on the first timer's underflow in the same cycle. A value of 1 counts on `tick_d16`.
- R6: Control bit 2 set to 0 makes a write to the second timer load both its latch and its counter. Set to 1, the write loads only the latch, and the counter takes that value at its next underflow. The first and third timers always load both.
- R7: When a write that loads a counter falls in the same cycle as a reload or a decrement of that counter, the written value wins. When a latch-only write coincides with an underflow, the reload uses the newly written value.
- R8: `irq[i]` is high for exactly the cycle after timer i+1 underflows. Bit 0 belongs to the first timer.
- R9: With control bit 0 set, `tgl_out` inverts one cycle after each underflow of the second timer.
- R10: Control bit 1 selects the start level: 0 starts high and 1 starts low. A control write that sets bit 0 from 0, or that changes bit 1, restarts `tgl_out` at the new start level. While bit 0 is 0, `tgl_out` holds the start level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_d16 | input | 1 | Divide-by-16 tick enable |
| tick_d2 | input | 1 | Divide-by-2 tick enable |
| tick_sub | input | 1 | Sub-clock tick enable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write target: 0 control, 1..3 timers |
| wr_data | input | W | Write data |
| rd_addr | input | 2 | Read select: 0 control, 1..3 timer counts |
| rd_data | output | W | Registered read data |
| irq | output | 3 | Per-timer underflow pulses |
| tgl_out | output | 1 | Toggle output driven by the second timer |

## Verification
The bench builds the block with the default width W = 8. With that width, small latch values reach an underflow within a few ticks, and the wrap past zero and the reload from all ones are reached quickly. Write data is mostly kept below 8, so underflows happen often. That makes writes regularly coincide with reloads, chained underflows and toggle restarts, and those cases are compared against the reference model in every cycle.

// File: rtl/rtim_pkg.sv
package rtim_pkg;
  localparam int NTMR = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_T1   = 2'd1;
  localparam logic [1:0] ADDR_T2   = 2'd2;
  localparam logic [1:0] ADDR_T3   = 2'd3;

  // control register layout, bit 0 is the LSB
  typedef struct packed {
    logic       pad;        // b7, never stored
    logic       t3_d16;     // b6
    logic [1:0] t1_src;     // b5:4
    logic       t2_d16;     // b3
    logic       t2_lonly;   // b2
    logic       tgl_lo;     // b1
    logic       tgl_en;     // b0
  } ctrl_t;

  // unified source code decoded by rtim_srcsel
  localparam logic [2:0] SRC_D16  = 3'b000;
  localparam logic [2:0] SRC_D2   = 3'b001;
  localparam logic [2:0] SRC_SUB  = 3'b010;
  localparam logic [2:0] SRC_CASC = 3'b100;
  localparam logic [2:0] SRC_NONE = 3'b011;

  function automatic logic [2:0] head_code(input logic [1:0] sel);
    return (sel == 2'b11) ? SRC_NONE : {1'b0, sel};
  endfunction

  function automatic logic [2:0] chain_code(input logic use_d16);
    return use_d16 ? SRC_D16 : SRC_CASC;
  endfunction
endpackage

// File: rtl/rtim_srcsel.sv
module rtim_srcsel
  import rtim_pkg::*;
(
  input  logic [2:0] code,
  input  logic       tick_d16,
  input  logic       tick_d2,
  input  logic       tick_sub,
  input  logic       casc_uf,
  output logic       cnt_en
);
  always_comb begin
    unique case (code)
      SRC_D16:  cnt_en = tick_d16;
      SRC_D2:   cnt_en = tick_d2;
      SRC_SUB:  cnt_en = tick_sub;
      SRC_CASC: cnt_en = casc_uf;
      default:  cnt_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtim_counter.sv
module rtim_counter #(
  parameter int W = 8,
  parameter bit ALLOW_LONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         wr_hit,
  input  logic         lonly_req,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_q,
  output logic         uf,
  output logic         irq_q
);
  logic [W-1:0] latch_q;
  logic         lonly;
  logic [W-1:0] reload_v;

  assign lonly    = ALLOW_LONLY && lonly_req;
  assign uf       = cnt_en && (cnt_q == '0);
  assign reload_v = wr_hit ? wr_data : latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      cnt_q   <= '1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= uf;
      if (wr_hit) latch_q <= wr_data;
      if (wr_hit && !lonly) cnt_q <= wr_data;
      else if (uf)          cnt_q <= reload_v;
      else if (cnt_en)      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtim_toggle.sv
module rtim_toggle (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic new_en,
  input  logic new_lo,
  input  logic cur_en,
  input  logic cur_lo,
  input  logic uf_src,
  output logic tgl_q
);
  logic restart;
  assign restart = ctrl_wr && ((new_en && !cur_en) || (new_lo != cur_lo));

  always_ff @(posedge clk) begin
    if (rst)          tgl_q <= 1'b1;
    else if (restart) tgl_q <= !new_lo;
    else if (!cur_en) tgl_q <= !cur_lo;
    else if (uf_src)  tgl_q <= !tgl_q;
  end
endmodule

// File: rtl/rtim_group.sv
module rtim_group
  import rtim_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_d16,
  input  logic         tick_d2,
  input  logic         tick_sub,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic [2:0]   irq,
  output logic         tgl_out
);
  localparam int CW = $bits(ctrl_t);

  ctrl_t                     ctrl_q;
  ctrl_t                     ctrl_d;
  logic                      ctrl_wr;
  logic [NTMR-1:0][W-1:0]    cnt_all;
  logic [NTMR-1:0]           en_v;
  logic [NTMR-1:0]           uf_v;
  logic [NTMR-1:0]           hit_v;
  logic                      en_t1;
  logic                      uf_t1;
  logic [W-1:0]              cnt_t1;
  logic                      irq_t1;
  logic [CW-1:0]             wr_low;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_low  = wr_data[CW-1:0];
  assign ctrl_d  = ctrl_t'({1'b0, wr_low[CW-2:0]});

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  // first timer: the head of the chain
  rtim_srcsel u_src_t1 (
    .code     (head_code(ctrl_q.t1_src)),
    .tick_d16 (tick_d16),
    .tick_d2  (tick_d2),
    .tick_sub (tick_sub),
    .casc_uf  (1'b0),
    .cnt_en   (en_t1)
  );

  rtim_counter #(.W(W), .ALLOW_LONLY(1'b0)) u_cnt_t1 (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (en_t1),
    .wr_hit    (wr_en && (wr_addr == ADDR_T1)),
    .lonly_req (1'b0),
    .wr_data   (wr_data),
    .cnt_q     (cnt_t1),
    .uf        (uf_t1),
    .irq_q     (irq_t1)
  );

  assign en_v[0]    = en_t1;
  assign uf_v[0]    = uf_t1;
  assign cnt_all[0] = cnt_t1;
  assign irq[0]     = irq_t1;
  assign hit_v[0]   = wr_en && (wr_addr == ADDR_T1);

  // chained timers
  for (genvar j = 1; j < NTMR; j++) begin : g_chain
    logic use_d16;
    logic en_j;
    logic uf_j;
    logic irq_j;
    logic [W-1:0] cnt_j;

    assign use_d16  = (j == 1) ? ctrl_q.t2_d16 : ctrl_q.t3_d16;
    assign hit_v[j] = wr_en && (wr_addr == 2'(j + 1));

    rtim_srcsel u_src (
      .code     (chain_code(use_d16)),
      .tick_d16 (tick_d16),
      .tick_d2  (tick_d2),
      .tick_sub (tick_sub),
      .casc_uf  (uf_t1),
      .cnt_en   (en_j)
    );

    rtim_counter #(.W(W), .ALLOW_LONLY(j == 1)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .cnt_en    (en_j),
      .wr_hit    (hit_v[j]),
      .lonly_req (ctrl_q.t2_lonly),
      .wr_data   (wr_data),
      .cnt_q     (cnt_j),
      .uf        (uf_j),
      .irq_q     (irq_j)
    );

    assign en_v[j]    = en_j;
    assign uf_v[j]    = uf_j;
    assign cnt_all[j] = cnt_j;
    assign irq[j]     = irq_j;
  end

  rtim_toggle u_tgl (
    .clk     (clk),
    .rst     (rst),
    .ctrl_wr (ctrl_wr),
    .new_en  (ctrl_d.tgl_en),
    .new_lo  (ctrl_d.tgl_lo),
    .cur_en  (ctrl_q.tgl_en),
    .cur_lo  (ctrl_q.tgl_lo),
    .uf_src  (uf_v[1]),
    .tgl_q   (tgl_out)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (rd_addr)
        ADDR_CTRL: rd_data <= W'(ctrl_q);
        ADDR_T1:   rd_data <= cnt_all[0];
        ADDR_T2:   rd_data <= cnt_all[1];
        default:   rd_data <= cnt_all[2];
      endcase
    end
  end
endmodule

// File: rtl/rtim_group_chk.sv
module rtim_group_chk #(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [W-1:0]     wr_data,
  input logic [7:0]       ctrl_q,
  input logic [2:0][W-1:0] cnt_all,
  input logic [2:0]       en_v,
  input logic [2:0]       uf_v,
  input logic [2:0]       irq,
  input logic             tgl_out
);
  p_write_loads_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd1) |=> (cnt_all[0] == $past(wr_data)));

  p_reserved_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[5:4] == 2'b11 && !(wr_en && wr_addr == 2'd1)) |=> $stable(cnt_all[0]));

  p_latch_only_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd2 && ctrl_q[2] && !en_v[1]) |=> $stable(cnt_all[1]));

  p_irq_after_uf_r8: assert property (@(posedge clk) disable iff (rst)
    uf_v[2] |=> irq[2]);

  p_toggle_flip_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[0] && uf_v[1] && !(wr_en && wr_addr == 2'd0)) |=> (tgl_out != $past(tgl_out)));

  p_disabled_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[0] && !(wr_en && wr_addr == 2'd0)) |=> (tgl_out == !$past(ctrl_q[1])));
endmodule

bind rtim_group rtim_group_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .ctrl_q  (ctrl_q),
  .cnt_all (cnt_all),
  .en_v    (en_v),
  .uf_v    (uf_v),
  .irq     (irq),
  .tgl_out (tgl_out)
);

// File: tb/rtim_group_tb.sv
`timescale 1ns/1ps
module rtim_group_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_d16 = 1'b0, tick_d2 = 1'b0, tick_sub = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [2:0]   irq;
  logic         tgl_out;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    armed = 1'b0;
  bit    done  = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  rtim_group #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .tick_d16(tick_d16), .tick_d2(tick_d2), .tick_sub(tick_sub),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .tgl_out(tgl_out)
  );

  // behavioural reference model
  int m_ctrl, m_tg, m_rd;
  int m_c[3], m_l[3], m_irq[3];

  always @(posedge clk) begin : ref_model
    int en[3], uf[3], om, nm, rdv;
    bit wm, hit, lonly;
    if (rst) begin
      m_ctrl = 0; m_tg = 1; m_rd = 0;
      for (int i = 0; i < 3; i++) begin m_c[i] = 255; m_l[i] = 255; m_irq[i] = 0; end
    end else begin
      om  = m_ctrl;
      rdv = (rd_addr == 0) ? om : m_c[rd_addr - 1];
      case ((om >> 4) & 3)
        0: en[0] = tick_d16;
        1: en[0] = tick_d2;
        2: en[0] = tick_sub;
        default: en[0] = 0;
      endcase
      uf[0] = (en[0] != 0 && m_c[0] == 0) ? 1 : 0;
      en[1] = ((om >> 3) & 1) ? int'(tick_d16) : uf[0];
      en[2] = ((om >> 6) & 1) ? int'(tick_d16) : uf[0];
      for (int i = 1; i < 3; i++) uf[i] = (en[i] != 0 && m_c[i] == 0) ? 1 : 0;
      for (int i = 0; i < 3; i++) begin
        hit   = wr_en && (int'(wr_addr) == i + 1);
        lonly = (i == 1) && (((om >> 2) & 1) == 1);
        if (hit) m_l[i] = int'(wr_data);
        if (hit && !lonly)   m_c[i] = int'(wr_data);
        else if (uf[i] != 0) m_c[i] = m_l[i];
        else if (en[i] != 0) m_c[i] = (m_c[i] + 255) % 256;
        m_irq[i] = uf[i];
      end
      wm = wr_en && (wr_addr == 0);
      nm = int'(wr_data) & 127;
      if (wm && ((((nm & 1) == 1) && ((om & 1) == 0)) || (((nm >> 1) & 1) != ((om >> 1) & 1))))
        m_tg = 1 - ((nm >> 1) & 1);
      else if ((om & 1) == 0) m_tg = 1 - ((om >> 1) & 1);
      else if (uf[1] != 0)    m_tg = 1 - m_tg;
      if (wm) m_ctrl = nm;
      m_rd = rdv;
    end
  end

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // compare away from the active edge, every cycle
  always @(negedge clk) begin
    if (armed && !done) begin
      check("rd_data", int'(rd_data), m_rd);
      for (int i = 0; i < 3; i++) check("irq", int'(irq[i]), m_irq[i]);
      check("tgl_out", int'(tgl_out), m_tg);
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic idle_inputs();
    tick_d16 = 0; tick_d2 = 0; tick_sub = 0; wr_en = 0;
  endtask

  task automatic set_ctrl(int v);
    @(negedge clk);
    idle_inputs();
    wr_en = 1; wr_addr = 2'd0; wr_data = W'(v);
    rd_addr = 2'($urandom % 4);
  endtask

  task automatic run(int n, int p16, int p2, int psub, int pwr, int dmax, int amask);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_d16 = (($urandom % 100) < p16);
      tick_d2  = (($urandom % 100) < p2);
      tick_sub = (($urandom % 100) < psub);
      wr_en    = (($urandom % 100) < pwr);
      wr_addr  = 2'(1 + ($urandom % 3));
      if (((amask >> wr_addr) & 1) == 0) wr_en = 0;
      wr_data  = W'($urandom % dmax);
      rd_addr  = 2'($urandom % 4);
    end
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin : stim
    void'($urandom(7));
    // R1: reset values visible on every read address
    repeat (3) @(negedge clk);
    rst = 0;
    armed = 1;
    for (int a = 0; a < 8; a++) begin @(negedge clk); rd_addr = 2'(a % 4); end
    @(negedge clk);
    check("R1 tgl reset", int'(tgl_out), 1);

    // R2: control write and readback with bit 7 cleared
    cur_req = "R2";
    set_ctrl(8'hFF);
    @(negedge clk); idle_inputs(); rd_addr = 2'd0;
    @(negedge clk);
    @(negedge clk);
    check("R2 ctrl readback", int'(rd_data), 8'h7F);
    run(40, 0, 0, 0, 50, 256, 14);

    // R3: plain counting on tick_d16 with cascaded followers
    cur_req = "R3";
    set_ctrl(8'h00);
    run(1500, 60, 0, 0, 2, 8, 14);

    // R4: every first-timer source, including the reserved code
    cur_req = "R4";
    for (int s = 0; s < 4; s++) begin
      set_ctrl((s << 4) | 8'h48);
      run(800, 40, 50, 30, 2, 8, 14);
    end

    // R5: cascade versus tick_d16 for the followers
    cur_req = "R5";
    set_ctrl(8'h10);
    run(1500, 30, 90, 0, 2, 6, 14);
    set_ctrl(8'h48);
    run(800, 50, 0, 0, 2, 6, 14);

    // R6: latch-only writes to the second timer
    cur_req = "R6";
    set_ctrl(8'h0C);
    run(1500, 50, 0, 0, 20, 8, 4);
    set_ctrl(8'h08);
    run(500, 50, 0, 0, 20, 8, 4);

    // R7: writes colliding with reloads and decrements
    cur_req = "R7";
    set_ctrl(8'h14);
    run(1500, 95, 95, 95, 60, 4, 14);
    set_ctrl(8'h1C);
    run(1500, 95, 95, 95, 60, 4, 14);

    // R8: dense underflows for interrupt pulses
    cur_req = "R8";
    set_ctrl(8'h10);
    run(1500, 100, 100, 0, 5, 3, 14);

    // R9: toggle output following the second timer
    cur_req = "R9";
    set_ctrl(8'h19);
    run(1500, 70, 80, 0, 3, 5, 14);

    // R10: start level, restarts and hold while disabled
    cur_req = "R10";
    for (int r = 0; r < 6; r++) begin
      set_ctrl(8'h18 | (r % 4));
      run(300, 70, 80, 0, 3, 5, 14);
    end
    set_ctrl(8'h1B);
    @(negedge clk); idle_inputs();
    @(negedge clk);
    check("R10 restart low", int'(tgl_out), 0);
    set_ctrl(8'h1A);
    @(negedge clk); idle_inputs();
    @(negedge clk);
    check("R10 disabled low", int'(tgl_out), 0);

    @(negedge clk); idle_inputs();
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule